// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

The block stores data between an A port and a B port in either direction. It is built from independent 8-bit sections. Each section has two latch banks: one carries A to B and the other carries B to A. Each bank has three active-low controls of its own: an entry enable, a latch enable and an output enable.

A bank is transparent while both its entry enable and its latch enable are low. Raising either of those two controls freezes the bank on the source value it held in the last cycle before the rise. The destination port is driven with the bank's contents only while the entry enable and the output enable are both low. Data passes through without inversion.

Each port is split into three signals: an input value, an output value and an output-enable. The input side also carries a flag that says an outside agent is driving the pin. With the bus-keeper option on, an undriven port shows the last value it carried. That value is either what an outside agent drove or what the block drove itself, so a bank never captures a floating level.

The latches are modelled on a fast system clock. Transparency acts within the same cycle, and captures are held in flops, so no level latch is inferred.

Top module: `bus_xcvr_latched`

## Requirements
- R1: After reset is released, every latch bank and every bus keeper holds 0. A port whose direction is enabled but has not yet been loaded therefore shows 0x00.
- R2: While a bank's entry enable and latch enable are both low, its destination output value equals the source port value in the same cycle.
- R3: When the latch enable rises while the entry enable is low, the bank keeps the source value of the cycle before the rise.
- R4: When the entry enable rises while the latch enable is low, the bank keeps the source value of the cycle before the rise.
- R5: While the latch enable stays high, the bank's output value does not change, whatever the source port does.
- R6: A destination output-enable bit is 1 exactly when that direction's entry enable and output enable are both low. Otherwise the port is treated as high impedance.
- R7: Captures happen while the output enable is high. The stored value appears once the output enable goes low.
- R8: The B-to-A banks follow R2 to R7 using their own three controls. Controls of one section or direction have no effect on the other banks.
- R9: With the bus keeper on, a port whose drive flag is 0 shows its last registered value to its bank. That value is the outside value when the drive flag was 1, or the block's own output when its output-enable was 1.
- R10: Data is never inverted. Each output bit n carries source bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system sampling clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| a_i | input | 16 | A pin value seen from outside, 8 bits per section |
| a_drv_i | input | 2 | 1 = an outside agent drives that section's A pins |
| b_i | input | 16 | B pin value seen from outside |
| b_drv_i | input | 2 | 1 = an outside agent drives that section's B pins |
| eab_n_i | input | 2 | A-to-B entry enable per section, active low |
| leab_n_i | input | 2 | A-to-B latch enable per section, active low |
| oeab_n_i | input | 2 | A-to-B output enable per section, active low |
| eba_n_i | input | 2 | B-to-A entry enable per section, active low |
| leba_n_i | input | 2 | B-to-A latch enable per section, active low |
| oeba_n_i | input | 2 | B-to-A output enable per section, active low |
| a_o | output | 16 | value driven onto the A pins |
| a_oe_o | output | 2 | 1 = block drives that section's A pins |
| b_o | output | 16 | value driven onto the B pins |
| b_oe_o | output | 2 | 1 = block drives that section's B pins |

## Verification
The transparency and capture assertions assume the source port is driven from outside (drive flag 1) in the cycles they compare. In those cycles the bank's source is the raw pin value rather than the keeper. The stimulus never drives a port from outside while the block's output-enable for that port is 1, so no port sees two drivers. Control changes are applied once per clock, away from the sampling edge, so each rise of an enable is seen as a single-cycle transition.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // per-direction control set, all active low
  typedef struct packed {
    logic entry_n;
    logic latch_n;
    logic oe_n;
  } dir_ctrl_t;
endpackage

// File: rtl/xcvr_bank.sv
module xcvr_bank
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  dir_ctrl_t    ctrl_i,
  output logic [W-1:0] q_o,
  output logic         oe_o
);
  logic [W-1:0] store_q;
  logic         open_w;

  assign open_w = !ctrl_i.entry_n && !ctrl_i.latch_n;

  // loading every open cycle makes any rise of entry/latch a capture of the prior value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     store_q <= '0;
    else if (open_w) store_q <= src_i;
  end

  assign q_o  = open_w ? src_i : store_q;
  assign oe_o = !ctrl_i.entry_n && !ctrl_i.oe_n;
endmodule

// File: rtl/xcvr_hold.sv
module xcvr_hold #(
  parameter int W       = 8,
  parameter bit HOLD_EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic         drv_i,
  input  logic [W-1:0] own_i,
  input  logic         own_oe_i,
  output logic [W-1:0] src_o
);
  if (HOLD_EN) begin : g_keep
    logic [W-1:0] held_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       held_q <= '0;
      else if (drv_i)    held_q <= pin_i;
      else if (own_oe_i) held_q <= own_i;
    end
    // registered own value keeps the A/B paths free of combinational loops
    assign src_o = drv_i ? pin_i : held_q;
  end else begin : g_pass
    logic unused_w;
    assign unused_w = ^{clk_i, rst_ni, drv_i, own_i, own_oe_i};
    assign src_o    = pin_i;
  end
endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
  import xcvr_pkg::*;
#(
  parameter int W       = 8,
  parameter bit HOLD_EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic         a_drv_i,
  input  logic [W-1:0] b_i,
  input  logic         b_drv_i,
  input  dir_ctrl_t    ab_ctrl_i,
  input  dir_ctrl_t    ba_ctrl_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  output logic [W-1:0] b_o,
  output logic         b_oe_o
);
  logic [W-1:0] a_src, b_src;

  xcvr_hold #(.W(W), .HOLD_EN(HOLD_EN)) u_hold_a (
    .clk_i, .rst_ni, .pin_i(a_i), .drv_i(a_drv_i),
    .own_i(a_o), .own_oe_i(a_oe_o), .src_o(a_src)
  );
  xcvr_hold #(.W(W), .HOLD_EN(HOLD_EN)) u_hold_b (
    .clk_i, .rst_ni, .pin_i(b_i), .drv_i(b_drv_i),
    .own_i(b_o), .own_oe_i(b_oe_o), .src_o(b_src)
  );

  xcvr_bank #(.W(W)) u_ab (
    .clk_i, .rst_ni, .src_i(a_src), .ctrl_i(ab_ctrl_i), .q_o(b_o), .oe_o(b_oe_o)
  );
  xcvr_bank #(.W(W)) u_ba (
    .clk_i, .rst_ni, .src_i(b_src), .ctrl_i(ba_ctrl_i), .q_o(a_o), .oe_o(a_oe_o)
  );
endmodule

// File: rtl/bus_xcvr_latched.sv
module bus_xcvr_latched
  import xcvr_pkg::*;
#(
  parameter int NUM_SECT = 2,
  parameter int SECT_W   = 8,
  parameter bit HOLD_EN  = 1'b1,
  localparam int BUS_W   = NUM_SECT * SECT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [BUS_W-1:0]    a_i,
  input  logic [NUM_SECT-1:0] a_drv_i,
  input  logic [BUS_W-1:0]    b_i,
  input  logic [NUM_SECT-1:0] b_drv_i,
  input  logic [NUM_SECT-1:0] eab_n_i,
  input  logic [NUM_SECT-1:0] leab_n_i,
  input  logic [NUM_SECT-1:0] oeab_n_i,
  input  logic [NUM_SECT-1:0] eba_n_i,
  input  logic [NUM_SECT-1:0] leba_n_i,
  input  logic [NUM_SECT-1:0] oeba_n_i,
  output logic [BUS_W-1:0]    a_o,
  output logic [NUM_SECT-1:0] a_oe_o,
  output logic [BUS_W-1:0]    b_o,
  output logic [NUM_SECT-1:0] b_oe_o
);
  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    dir_ctrl_t ab_ctrl, ba_ctrl;
    assign ab_ctrl = '{entry_n: eab_n_i[s], latch_n: leab_n_i[s], oe_n: oeab_n_i[s]};
    assign ba_ctrl = '{entry_n: eba_n_i[s], latch_n: leba_n_i[s], oe_n: oeba_n_i[s]};

    xcvr_section #(.W(SECT_W), .HOLD_EN(HOLD_EN)) u_sect (
      .clk_i,
      .rst_ni,
      .a_i      (a_i[s*SECT_W +: SECT_W]),
      .a_drv_i  (a_drv_i[s]),
      .b_i      (b_i[s*SECT_W +: SECT_W]),
      .b_drv_i  (b_drv_i[s]),
      .ab_ctrl_i(ab_ctrl),
      .ba_ctrl_i(ba_ctrl),
      .a_o      (a_o[s*SECT_W +: SECT_W]),
      .a_oe_o   (a_oe_o[s]),
      .b_o      (b_o[s*SECT_W +: SECT_W]),
      .b_oe_o   (b_oe_o[s])
    );
  end
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int NUM_SECT = 2,
  parameter int SECT_W   = 8,
  localparam int BUS_W   = NUM_SECT * SECT_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [BUS_W-1:0]    a_i,
  input logic [NUM_SECT-1:0] a_drv_i,
  input logic [BUS_W-1:0]    b_i,
  input logic [NUM_SECT-1:0] b_drv_i,
  input logic [NUM_SECT-1:0] eab_n_i,
  input logic [NUM_SECT-1:0] leab_n_i,
  input logic [NUM_SECT-1:0] oeab_n_i,
  input logic [NUM_SECT-1:0] eba_n_i,
  input logic [NUM_SECT-1:0] leba_n_i,
  input logic [NUM_SECT-1:0] oeba_n_i,
  input logic [BUS_W-1:0]    a_o,
  input logic [NUM_SECT-1:0] a_oe_o,
  input logic [BUS_W-1:0]    b_o,
  input logic [NUM_SECT-1:0] b_oe_o
);
  logic seen_q;  // one full cycle out of reset before $past is trusted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_chk
    localparam int LO = s * SECT_W;

    assert_transparent_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!eab_n_i[s] && !leab_n_i[s] && a_drv_i[s]) |-> (b_o[LO +: SECT_W] == a_i[LO +: SECT_W]));

    assert_transparent_ba_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!eba_n_i[s] && !leba_n_i[s] && b_drv_i[s]) |-> (a_o[LO +: SECT_W] == b_i[LO +: SECT_W]));

    assert_latch_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && !$past(eab_n_i[s]) && !$past(leab_n_i[s]) && $past(a_drv_i[s])
       && !eab_n_i[s] && $rose(leab_n_i[s]))
      |-> (b_o[LO +: SECT_W] == $past(a_i[LO +: SECT_W])));

    assert_entry_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && !$past(eab_n_i[s]) && !$past(leab_n_i[s]) && $past(a_drv_i[s])
       && !leab_n_i[s] && $rose(eab_n_i[s]))
      |-> (b_o[LO +: SECT_W] == $past(a_i[LO +: SECT_W])));

    assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && leab_n_i[s] && $past(leab_n_i[s])) |-> $stable(b_o[LO +: SECT_W]));

    assert_oe_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (oeab_n_i[s] || eab_n_i[s]) |-> !b_oe_o[s]);
  end
endmodule

bind bus_xcvr_latched xcvr_chk #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .a_drv_i(a_drv_i), .b_i(b_i), .b_drv_i(b_drv_i),
  .eab_n_i(eab_n_i), .leab_n_i(leab_n_i), .oeab_n_i(oeab_n_i),
  .eba_n_i(eba_n_i), .leba_n_i(leba_n_i), .oeba_n_i(oeba_n_i),
  .a_o(a_o), .a_oe_o(a_oe_o), .b_o(b_o), .b_oe_o(b_oe_o)
);

// File: tb/bus_xcvr_latched_tb.sv
module bus_xcvr_latched_tb;
  localparam int NS = 2;
  localparam int SW = 8;
  localparam int BW = NS * SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [BW-1:0] a_in = '0, b_in = '0;
  logic [NS-1:0] a_drv = '0, b_drv = '0;
  logic [NS-1:0] eab = '1, leab = '1, oeab = '1, eba = '1, leba = '1, oeba = '1;
  logic [BW-1:0] a_out, b_out;
  logic [NS-1:0] a_oe, b_oe;

  bus_xcvr_latched #(.NUM_SECT(NS), .SECT_W(SW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_in), .a_drv_i(a_drv), .b_i(b_in), .b_drv_i(b_drv),
    .eab_n_i(eab), .leab_n_i(leab), .oeab_n_i(oeab),
    .eba_n_i(eba), .leba_n_i(leba), .oeba_n_i(oeba),
    .a_o(a_out), .a_oe_o(a_oe), .b_o(b_out), .b_oe_o(b_oe)
  );

  typedef struct {
    logic [BW-1:0] a, b;
    logic [NS-1:0] aoe, boe;
    string         tag;
  } exp_t;
  exp_t sb_q[$];

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference state, from the requirements
  logic [SW-1:0] m_ab [NS];
  logic [SW-1:0] m_ba [NS];
  logic [SW-1:0] m_ha [NS];
  logic [SW-1:0] m_hb [NS];

  task automatic step(input string tag);
    exp_t e;
    e.tag = tag;
    for (int s = 0; s < NS; s++) begin
      logic [SW-1:0] sa, sb;
      logic open_ab, open_ba;
      sa = a_drv[s] ? a_in[s*SW +: SW] : m_ha[s];
      sb = b_drv[s] ? b_in[s*SW +: SW] : m_hb[s];
      open_ab = !eab[s] && !leab[s];
      open_ba = !eba[s] && !leba[s];
      e.b[s*SW +: SW] = open_ab ? sa : m_ab[s];
      e.a[s*SW +: SW] = open_ba ? sb : m_ba[s];
      e.boe[s] = !eab[s] && !oeab[s];
      e.aoe[s] = !eba[s] && !oeba[s];
      if (open_ab) m_ab[s] = sa;
      if (open_ba) m_ba[s] = sb;
      if (a_drv[s]) m_ha[s] = a_in[s*SW +: SW];
      else if (e.aoe[s]) m_ha[s] = e.a[s*SW +: SW];
      if (b_drv[s]) m_hb[s] = b_in[s*SW +: SW];
      else if (e.boe[s]) m_hb[s] = e.b[s*SW +: SW];
    end
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: sample mid-cycle, before the next rising edge
  always begin
    @(negedge clk);
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (a_out !== e.a || b_out !== e.b || a_oe !== e.aoe || b_oe !== e.boe) begin
        errors++;
        $display("FAIL %s: a=%h/%b b=%h/%b expected a=%h/%b b=%h/%b",
                 e.tag, a_out, a_oe, b_out, b_oe, e.a, e.aoe, e.b, e.boe);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      m_ab[s] = '0; m_ba[s] = '0; m_ha[s] = '0; m_hb[s] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: enabled but never loaded shows zero
    eab[0] = 0; oeab[0] = 0; eba[1] = 0; oeba[1] = 0;
    step("R1");
    eba[1] = 1; oeba[1] = 1;

    // R2 / R10: transparent A->B, several patterns
    leab[0] = 0; a_drv[0] = 1;
    a_in[7:0] = 8'hA5; step("R2");
    a_in[7:0] = 8'h3C; step("R2");
    a_in[7:0] = 8'h81; step("R10");

    // R3: latch-enable rise keeps prior value; R5: hold
    a_in[7:0] = 8'h5A; step("R2");
    leab[0] = 1; a_in[7:0] = 8'hFF; step("R3");
    a_in[7:0] = 8'h00; step("R5");
    a_in[7:0] = 8'hC3; step("R5");

    // R4: entry-enable rise keeps prior value
    leab[0] = 0; a_in[7:0] = 8'h66; step("R2");
    eab[0] = 1; a_in[7:0] = 8'h99; step("R4");
    leab[0] = 1; step("R5");
    eab[0] = 0; step("R4");

    // R6 / R7: capture with output disabled
    oeab[0] = 1; leab[0] = 0; a_in[7:0] = 8'h21; step("R6");
    leab[0] = 1; a_in[7:0] = 8'h00; step("R7");
    oeab[0] = 0; step("R7");

    // R8: section 1 B->A, section 0 untouched
    eba[1] = 0; oeba[1] = 0; leba[1] = 0; b_drv[1] = 1;
    b_in[15:8] = 8'hE7; step("R8");
    leba[1] = 1; b_in[15:8] = 8'h18; step("R8");
    eab[1] = 1; a_in[7:0] = 8'h42; step("R8");

    // R9: keeper retains last outside value
    leab[0] = 0; a_in[7:0] = 8'h77; step("R9");
    a_drv[0] = 0; a_in[7:0] = 8'h00; step("R9");
    a_in[7:0] = 8'hFF; step("R9");

    // R9: keeper retains value the block drove on A (section 1)
    eab[1] = 0; leab[1] = 0; step("R9");
    leab[1] = 1; eba[1] = 1; step("R9");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule